// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked stand-in for a retriggerable monostable. Three level inputs control it: an active-low trigger, an active-high trigger and an active-low clear. It drives a single pulse output. A cycle count sampled from a width bus at each trigger sets how long the pulse lasts. Every control input passes through a two-flop synchronizer. Each one is then qualified by a stability filter before its edges are detected, so short glitches cannot fire the block.

A trigger that arrives while a pulse is running reloads the full count, which stretches the pulse. Driving the clear input low ends any pulse and blocks new triggers. Releasing the clear while the two triggers sit in their armed levels (low trigger low, high trigger high) starts a pulse. The block fits wherever a delayed, stretchable strobe is needed from slow or asynchronous control lines.

Top module: `retrig_oneshot`

## Requirements
- R1: With `trg_lo_i` held at 0 and `clr_n_i` at 1, a rise of `trg_hi_i` starts a pulse. `pulse_o` goes high exactly 3+FILT clock cycles after the input changes.
- R2: With `trg_hi_i` held at 1 and `clr_n_i` at 1, a fall of `trg_lo_i` starts a pulse, with the same 3+FILT cycle latency.
- R3: With `trg_lo_i` at 0 and `trg_hi_i` at 1, a rise of `clr_n_i` starts a pulse, with the same latency.
- R4: A fall of `clr_n_i` drives `pulse_o` low 3+FILT cycles after the input changes, ending any pulse in progress. No trigger is accepted while the filtered clear is low.
- R5: No pulse starts when `trg_hi_i` rises while `trg_lo_i` is 1, or when `trg_lo_i` falls while `trg_hi_i` is 0. Rises of `trg_lo_i` and falls of `trg_hi_i` never start a pulse.
- R6: A valid trigger on `trg_lo_i` or `trg_hi_i` during a pulse reloads the count. The total high time equals the cycles already elapsed at the reload plus the width sampled at the reload.
- R7: `width_i` is sampled only in the cycle a trigger is accepted. A width W of 1 or more gives W cycles high, and a width of 0 gives exactly one cycle high. Changing `width_i` during a pulse has no effect on that pulse.
- R8: A change on any control input that lasts fewer than FILT cycles at the synchronizer output is ignored. A change that lasts FILT cycles is accepted.
- R9: If the clear rises in the same filtered cycle in which other trigger conditions hold, exactly one pulse of the sampled width is produced.
- R10: While `rst_n` is low, and after it is released with no trigger, `pulse_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trg_lo_i | input | 1 | Active-low trigger (falling edge fires) |
| trg_hi_i | input | 1 | Active-high trigger (rising edge fires) |
| clr_n_i | input | 1 | Active-low clear; its rising edge can also fire |
| width_i | input | CW | Pulse length in clock cycles, sampled at trigger |
| pulse_o | output | 1 | Registered pulse output |

## Verification
A corrupted down-counter shows up as a pulse that is too short or too long, at the first cycle the pulse should have ended. A wrong filter or edge state shows up as a missing pulse or an extra pulse, or as a rise or fall that does not land exactly 3+FILT cycles after the stimulus. Each scenario therefore measures both the rise cycle and the fall cycle against values computed from the stimulus time. A clear path that lets triggers through shows up as an extra pulse within 3+FILT cycles of the blocked trigger.

// File: rtl/retrig_oneshot.sv
module retrig_oneshot #(
  parameter int CW   = 8,
  parameter int FILT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trg_lo_i,
  input  logic          trg_hi_i,
  input  logic          clr_n_i,
  input  logic [CW-1:0] width_i,
  output logic          pulse_o
);
  localparam int NIN = 3;
  localparam int FW  = (FILT > 1) ? $clog2(FILT) : 1;
  localparam logic [NIN-1:0] IDLE = 3'b101;

  logic [NIN-1:0] raw, s1, s2, filt, prev;
  logic [CW-1:0]  cnt;
  logic           q;
  logic           a_f, b_f, c_f, fire;

  assign raw = {clr_n_i, trg_hi_i, trg_lo_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1   <= IDLE;
      s2   <= IDLE;
      prev <= IDLE;
    end else begin
      s1   <= raw;
      s2   <= s1;
      prev <= filt;
    end

  for (genvar i = 0; i < NIN; i++) begin : g_flt
    logic [FW-1:0] fc;
    logic          fv;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        fc <= '0;
        fv <= IDLE[i];
      end else if (s2[i] == fv) begin
        fc <= '0;
      end else if (fc == FW'(FILT - 1)) begin
        fc <= '0;
        fv <= s2[i];
      end else begin
        fc <= fc + FW'(1);
      end
    assign filt[i] = fv;

    AST_FLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (filt[i] != $past(filt[i])) |-> ($past(s2[i]) != $past(filt[i]))); // R8
  end

  assign a_f  = filt[0];
  assign b_f  = filt[1];
  assign c_f  = filt[2];
  assign fire = c_f & (( b_f & ~prev[1] & ~a_f)
                     | (~a_f &  prev[0] &  b_f)
                     | (~prev[2] & ~a_f & b_f));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (!c_f) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (fire) begin
      q   <= 1'b1;
      cnt <= width_i;
    end else if (q) begin
      if (cnt <= CW'(1)) begin
        q   <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end

  assign pulse_o = q;

  AST_CLR_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    !c_f |=> !pulse_o); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_o && !fire) |=> !pulse_o); // R5
  AST_FIRE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pulse_o && cnt == $past(width_i))); // R7
  AST_RETRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && fire) |=> pulse_o); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && !fire && c_f && cnt > CW'(1)) |=> (pulse_o && cnt == $past(cnt) - CW'(1))); // R7
endmodule

// File: tb/retrig_oneshot_tb.sv
module retrig_oneshot_tb_top;
  localparam int CW   = 8;
  localparam int FILT = 2;
  localparam int LAT  = 3 + FILT;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a = 1'b1, b = 1'b0, clr = 1'b1;
  logic [CW-1:0] w = '0;
  logic          q;
  logic          q_d = 1'b0;
  logic          done = 1'b0;
  int checks = 0, errors = 0;
  int cyc = 0, rise_at = -1, fall_at = -1, npulses = 0;

  retrig_oneshot #(.CW(CW), .FILT(FILT)) dut_i (
    .clk(clk), .rst_n(rst_n), .trg_lo_i(a), .trg_hi_i(b),
    .clr_n_i(clr), .width_i(w), .pulse_o(q));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (q && !q_d) begin rise_at = cyc; npulses++; end
    if (!q && q_d) fall_at = cyc;
    q_d = q;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    a = 1'b1; b = 1'b0; clr = 1'b1;
    idle(60);
  endtask

  task automatic arm_b(input int wv);
    w = wv[CW-1:0]; a = 1'b0; b = 1'b0; clr = 1'b1;
    idle(6);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 q during reset", int'(q), 0);
    end
    rst_n = 1'b1;
    idle(10);
    chk("R10 q after reset", int'(q), 0);
    chk("R10 no pulse after reset", npulses, 0);
  endtask

  task automatic t_b_rise();
    int n0, t0;
    arm_b(7);
    n0 = npulses;
    b = 1'b1; t0 = cyc;
    idle(30);
    chk("R1 one pulse", npulses, n0 + 1);
    chk("R1 latency", rise_at - t0, LAT);
    chk("R1 length", fall_at - rise_at, 7);
    go_idle();
  endtask

  task automatic t_a_fall();
    int n0, t0;
    w = 4; b = 1'b1;
    idle(6);
    n0 = npulses;
    a = 1'b0; t0 = cyc;
    idle(30);
    chk("R2 one pulse", npulses, n0 + 1);
    chk("R2 latency", rise_at - t0, LAT);
    chk("R2 length", fall_at - rise_at, 4);
    go_idle();
  endtask

  task automatic t_clr_rise();
    int n0, t0;
    w = 9; clr = 1'b0;
    idle(8);
    n0 = npulses;
    a = 1'b0; b = 1'b1;
    idle(12);
    chk("R4 trigger blocked while clear low", npulses, n0);
    clr = 1'b1; t0 = cyc;
    idle(30);
    chk("R3 one pulse", npulses, n0 + 1);
    chk("R3 latency", rise_at - t0, LAT);
    chk("R3 length", fall_at - rise_at, 9);
    go_idle();
  endtask

  task automatic t_no_trig();
    int n0;
    w = 5; n0 = npulses;
    b = 1'b1;
    idle(12);
    chk("R5 B rise with A high", npulses, n0);
    b = 1'b0;
    idle(8);
    a = 1'b0;
    idle(12);
    chk("R5 A fall with B low", npulses, n0);
    chk("R5 q stays low", int'(q), 0);
    go_idle();
  endtask

  task automatic t_retrig();
    int n0, t0, r;
    arm_b(20);
    n0 = npulses;
    b = 1'b1; t0 = cyc;
    idle(7);
    a = 1'b1;
    idle(5);
    a = 1'b0; r = cyc;
    idle(60);
    chk("R6 single stretched pulse", npulses, n0 + 1);
    chk("R6 first rise", rise_at - t0, LAT);
    chk("R6 total length", fall_at - rise_at, (r + LAT - rise_at) + 20);
    go_idle();
  endtask

  task automatic t_clear();
    int n0, c;
    arm_b(30);
    n0 = npulses;
    b = 1'b1;
    idle(10);
    clr = 1'b0; c = cyc;
    idle(10);
    chk("R4 clear cuts pulse", fall_at - c, LAT);
    chk("R4 q low under clear", int'(q), 0);
    b = 1'b0;
    idle(5);
    b = 1'b1;
    idle(12);
    chk("R4 no retrigger under clear", npulses, n0 + 1);
    go_idle();
  endtask

  task automatic t_width();
    int n0, t0;
    arm_b(0);
    n0 = npulses;
    b = 1'b1;
    idle(20);
    chk("R7 width 0 gives one cycle", fall_at - rise_at, 1);
    go_idle();
    arm_b(1);
    b = 1'b1;
    idle(20);
    chk("R7 width 1 gives one cycle", fall_at - rise_at, 1);
    go_idle();
    arm_b(6);
    b = 1'b1; t0 = cyc;
    idle(LAT + 2);
    w = 50;
    idle(70);
    chk("R7 width change ignored mid pulse", fall_at - rise_at, 6);
    chk("R7 pulse count", npulses, n0 + 3);
    go_idle();
  endtask

  task automatic t_glitch();
    int n0, t0;
    arm_b(3);
    n0 = npulses;
    b = 1'b1;
    idle(1);
    b = 1'b0;
    idle(15);
    chk("R8 short glitch ignored", npulses, n0);
    b = 1'b1; t0 = cyc;
    idle(FILT);
    b = 1'b0;
    idle(20);
    chk("R8 held input accepted", npulses, n0 + 1);
    chk("R8 latency of held input", rise_at - t0, LAT);
    go_idle();
    arm_b(25);
    b = 1'b1;
    idle(10);
    clr = 1'b0;
    idle(1);
    clr = 1'b1;
    idle(40);
    chk("R8 clear glitch does not cut", fall_at - rise_at, 25);
    go_idle();
  endtask

  task automatic t_concurrent();
    int n0, t0;
    w = 8; a = 1'b1; b = 1'b0; clr = 1'b0;
    idle(8);
    n0 = npulses;
    clr = 1'b1; a = 1'b0; b = 1'b1; t0 = cyc;
    idle(30);
    chk("R9 exactly one pulse", npulses, n0 + 1);
    chk("R9 latency", rise_at - t0, LAT);
    chk("R9 length", fall_at - rise_at, 8);
    go_idle();
  endtask

  initial begin
    t_reset();
    go_idle();
    t_b_rise();
    t_a_fall();
    t_clr_rise();
    t_no_trig();
    t_retrig();
    t_clear();
    t_width();
    t_glitch();
    t_concurrent();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule